// File: doc/BRIEF.md
# Periodic Tick Timer with Byte-Wide Reload

This block is a 16-bit down-counter that advances on a 32768 Hz count enable. It reloads itself from a value that software writes as two byte registers, so choosing a reload of 0x8000 shifted right by n produces an expiry rate of 2^n Hz. Each expiry sets a sticky flag, and that flag drives the interrupt output when the interrupt enable is set.

The timer runs in one of two modes. In repeating mode it reloads and keeps counting after every expiry. In one-shot mode it stops after the first expiry by clearing its own enable bit. A write to the count-clear address zeroes the running count before the timer is started. A read-only busy bit in the control byte stays high for a short settling window after every control write, and software polls it before it relies on the new setting.

All access goes through a byte register port that has an address, a write strobe, write data and combinational read data. The count-enable input is a single-cycle strobe in the system clock domain.

Top module: `tick_tmr`

## Requirements
- R1: After reset, the control byte (0x10), both reload bytes, the count and the interrupt output all read as zero.
- R2: The reload value is 16 bits wide, with the low byte at 0x12 and the high byte at 0x13. Both bytes read back as written.
- R3: The count changes only on a clock in which control bit 3 (enable) is 1 and tick_en is 1, or when the count-clear address is written. Ticks while the timer is disabled leave the count unchanged.
- R4: On a qualifying tick, a count of 0 or 1 loads the reload value and any higher count decrements by one. The tick whose result is a count of 1 sets control bit 1 (flag). From a cleared count with reload R, the first expiry therefore comes on tick R.
- R5: With control bit 0 = 1 (repeat), the timer stays enabled after an expiry and reloads on the next tick. With bit 0 = 0 (one-shot), the expiry clears bit 3, and later ticks leave the count at 1.
- R6: Writing the control byte with bit 1 = 1 clears the flag, and bit 1 = 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: irq_o is 1 exactly when the flag (bit 1) and the interrupt enable (bit 2) are both 1.
- R8: Any write to address 0x20 sets the count to 0 whatever the data. It takes priority over a tick in the same cycle.
- R9: Control bit 7 (busy) reads 1 during the two clock cycles that follow a control write and 0 otherwise. A written bit 7 is ignored.
- R10: Reads of 0x20 and 0x21 return the low and high byte of the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32768 Hz count strobe, one clock wide |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_o | output | 1 | Interrupt: flag AND interrupt enable |

## Verification
The bench targets the places where the count and the control bits meet. It sends a tick in the same cycle as a flag-clearing write, and an implementation that let the clear win would lose the expiry. It sends a tick in the same cycle as a count clear, and a wrong priority would leave the count at its reloaded value. It uses a reload of 1, where an off-by-one expiry test would never set the flag or would set it late. It checks that a one-shot expiry drops the enable and freezes the count at 1, where a faulty design would keep reloading. It samples the busy bit in each cycle of its window, which catches a window that is too short or never ends.

// File: rtl/tick_tmr_pkg.sv
package tick_tmr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] ADDR_CTRL   = 8'h10;
    localparam logic [7:0] ADDR_RLD_LO = 8'h12;
    localparam logic [7:0] ADDR_CNT_LO = 8'h20;

    localparam int BIT_BUSY = 7;
    localparam int BIT_EN   = 3;
    localparam int BIT_IE   = 2;
    localparam int BIT_FLAG = 1;
    localparam int BIT_MODE = 0;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_REPEAT  = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic      en;
        logic      ie;
        logic      flag;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    function automatic logic [7:0] ctrl_byte(tmr_ctrl_t c, logic busy);
        logic [7:0] b;
        b           = '0;
        b[BIT_BUSY] = busy;
        b[BIT_EN]   = c.en;
        b[BIT_IE]   = c.ie;
        b[BIT_FLAG] = c.flag;
        b[BIT_MODE] = c.mode;
        return b;
    endfunction
endpackage

// File: rtl/tick_tmr_core.sv
module tick_tmr_core
    import tick_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (run_i && tick_i) begin
            if (cnt_q <= ONE) cnt_d = reload_i;
            else              cnt_d = cnt_q - ONE;
            expire_o = (cnt_d == ONE);
        end
        if (clr_i) begin
            cnt_d    = '0;
            expire_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/tick_tmr_regs.sv
module tick_tmr_regs
    import tick_tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BUSY_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       reg_addr,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    input  logic             expire_i,
    input  logic [CNT_W-1:0] count_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             busy_o,
    output logic             clr_cnt_o,
    output logic [7:0]       reg_rdata
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int BW     = $clog2(BUSY_CYC + 1);

    tmr_ctrl_t   ctrl_q, ctrl_d;
    logic [BW-1:0] busy_q;
    logic        wr_ctrl;

    assign wr_ctrl   = reg_we && (reg_addr == ADDR_CTRL);
    assign clr_cnt_o = reg_we && (reg_addr == ADDR_CNT_LO);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.en   = reg_wdata[BIT_EN];
            ctrl_d.ie   = reg_wdata[BIT_IE];
            ctrl_d.mode = tmr_mode_e'(reg_wdata[BIT_MODE]);
            if (reg_wdata[BIT_FLAG]) ctrl_d.flag = 1'b0;
        end
        if (expire_i) begin
            ctrl_d.flag = 1'b1;
            if (ctrl_q.mode == MODE_ONESHOT && !wr_ctrl) ctrl_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            busy_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_ctrl)           busy_q <= BW'(BUSY_CYC);
            else if (busy_q != '0) busy_q <= busy_q - 1'b1;
        end
    end

    logic [7:0] rld_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_rld
        always_ff @(posedge clk) begin
            if (rst)
                rld_q[g] <= '0;
            else if (reg_we && reg_addr == ADDR_RLD_LO + 8'(g))
                rld_q[g] <= reg_wdata;
        end
        assign reload_o[BYTE_W*g +: BYTE_W] = rld_q[g];
    end

    assign busy_o = (busy_q != '0);
    assign ctrl_o = ctrl_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) reg_rdata = ctrl_byte(ctrl_q, busy_o);
        for (int i = 0; i < NBYTES; i++) begin
            if (reg_addr == ADDR_RLD_LO + 8'(i)) reg_rdata = rld_q[i];
            if (reg_addr == ADDR_CNT_LO + 8'(i)) reg_rdata = count_i[BYTE_W*i +: BYTE_W];
        end
    end
endmodule

// File: rtl/tick_tmr.sv
module tick_tmr
    import tick_tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BUSY_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [7:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o
);
    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             busy;
    logic             clr_cnt;
    logic             expire;

    tick_tmr_regs #(.CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .expire_i  (expire),
        .count_i   (count),
        .ctrl_o    (ctrl),
        .reload_o  (reload),
        .busy_o    (busy),
        .clr_cnt_o (clr_cnt),
        .reg_rdata (reg_rdata)
    );

    tick_tmr_core #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_en),
        .run_i    (ctrl.en),
        .clr_i    (clr_cnt),
        .reload_i (reload),
        .count_o  (count),
        .expire_o (expire)
    );

    assign irq_o = ctrl.flag & ctrl.ie;
endmodule

// File: rtl/tick_tmr_chk.sv
module tick_tmr_chk
    import tick_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic [7:0]       reg_addr,
    input logic             reg_we,
    input logic             irq_o,
    input tmr_ctrl_t        ctrl,
    input logic [CNT_W-1:0] count,
    input logic             busy
);
    logic clr_w, ctrl_w;
    assign clr_w  = reg_we && (reg_addr == ADDR_CNT_LO);
    assign ctrl_w = reg_we && (reg_addr == ADDR_CTRL);

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl.en && tick_en) && !clr_w) |=> $stable(count));

    // R4
    flag_at_one_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.flag) |-> (count == CNT_W'(1)));

    // R6
    expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && tick_en && count == CNT_W'(2) && !clr_w) |=> ctrl.flag);

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.mode == MODE_ONESHOT && tick_en && count == CNT_W'(2)
         && !clr_w && !ctrl_w) |=> !ctrl.en);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> (count == '0));

    // R9
    busy_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_w |=> busy);

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ctrl.flag && ctrl.ie));
endmodule

bind tick_tmr tick_tmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .irq_o    (irq_o),
    .ctrl     (ctrl),
    .count    (count),
    .busy     (busy)
);

// File: tb/tick_tmr_tb_top.sv
`timescale 1ns/1ps
module tick_tmr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int total = 0;
    int fail  = 0;
    bit done  = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    tick_tmr dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares against the ports.
    initial begin
        sb_item_t   it;
        logic [7:0] act;
        forever begin
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'b0, irq_o} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                fail++;
                $display("FAIL %s: addr %h actual %h expected %h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        reg_addr = a;
        #0.2;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #0.2;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        sb_item_t it;
        #0.2;
        it.is_irq = 1'b1; it.addr = 8'hFF; it.exp = {7'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        #0.2;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fail, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_chk(8'h10, 8'h00, "R1 ctrl reset");
        rd_chk(8'h12, 8'h00, "R1 reload reset");
        rd_chk(8'h20, 8'h00, "R1 count reset");
        irq_chk(1'b0, "R1 irq reset");

        wr(8'h12, 8'h03); wr(8'h13, 8'h00);
        rd_chk(8'h12, 8'h03, "R2 reload low");
        rd_chk(8'h13, 8'h00, "R2 reload high");

        tick(); tick(); tick();
        rd_chk(8'h20, 8'h00, "R3 disabled ticks ignored");

        wr(8'h10, 8'h0D);
        rd_chk(8'h10, 8'h8D, "R9 busy cycle 1");
        @(negedge clk);
        rd_chk(8'h10, 8'h8D, "R9 busy cycle 2");
        @(negedge clk);
        rd_chk(8'h10, 8'h0D, "R9 busy gone");

        tick(); rd_chk(8'h20, 8'h03, "R4 load from zero");
        tick(); rd_chk(8'h20, 8'h02, "R3 decrement");
        tick(); rd_chk(8'h20, 8'h01, "R4 reach one");
        rd_chk(8'h10, 8'h0F, "R4 flag set");
        irq_chk(1'b1, "R7 irq raised");
        tick(); rd_chk(8'h20, 8'h03, "R5 repeat reload");
        rd_chk(8'h10, 8'h0F, "R5 still enabled");

        wr(8'h10, 8'h0D); settle();
        rd_chk(8'h10, 8'h0F, "R6 zero leaves flag");
        wr(8'h10, 8'h0F); settle();
        rd_chk(8'h10, 8'h0D, "R6 w1c clears");
        irq_chk(1'b0, "R7 irq dropped");

        tick(); rd_chk(8'h20, 8'h02, "R3 decrement again");
        wr_tick(8'h10, 8'h0F); settle();
        rd_chk(8'h10, 8'h0F, "R6 set wins over clear");

        wr(8'h10, 8'h09); settle();
        irq_chk(1'b0, "R7 ie off masks irq");
        rd_chk(8'h10, 8'h0B, "R7 flag kept with ie off");

        wr(8'h20, 8'h5A);
        rd_chk(8'h20, 8'h00, "R8 clear count");
        tick(); rd_chk(8'h20, 8'h03, "R4 reload after clear");
        wr_tick(8'h20, 8'h00);
        rd_chk(8'h20, 8'h00, "R8 clear beats tick");

        wr(8'h12, 8'h02); wr(8'h10, 8'h0E); settle();
        rd_chk(8'h10, 8'h0C, "R5 one-shot armed");
        tick(); rd_chk(8'h20, 8'h02, "R5 one-shot load");
        tick(); rd_chk(8'h10, 8'h06, "R5 one-shot stops");
        irq_chk(1'b1, "R7 one-shot irq");
        tick(); rd_chk(8'h20, 8'h01, "R5 count frozen at one");

        wr(8'h12, 8'h00); wr(8'h13, 8'h08);
        rd_chk(8'h13, 8'h08, "R2 reload high byte");
        wr(8'h20, 8'h00); wr(8'h10, 8'h09); settle();
        rd_chk(8'h10, 8'h0B, "R9 settled ctrl");
        tick();
        rd_chk(8'h20, 8'h00, "R10 count low 0x0800");
        rd_chk(8'h21, 8'h08, "R10 count high 0x0800");
        tick();
        rd_chk(8'h20, 8'hFF, "R10 count low 0x07FF");
        rd_chk(8'h21, 8'h07, "R10 count high 0x07FF");

        wr(8'h13, 8'h00); wr(8'h12, 8'h01); wr(8'h20, 8'h00);
        wr(8'h10, 8'h0B); settle();
        rd_chk(8'h10, 8'h09, "R6 flag cleared before reload one");
        tick(); rd_chk(8'h10, 8'h0B, "R4 reload one expires at once");
        rd_chk(8'h20, 8'h01, "R4 count one");

        wr(8'h10, 8'h80); settle();
        rd_chk(8'h10, 8'h02, "R9 written busy bit ignored");

        done = 1'b1;
        wait (sb_q.size() == 0);
        #1;
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end
endmodule